// File: doc/BRIEF.md
# IF Digital Down Converter Decimator

This block turns a stream of real samples taken from an intermediate-frequency converter into complex baseband samples at a much lower rate. A numerically controlled oscillator, advanced by a runtime-programmable 32-bit tuning word, produces cosine and sine values from a quarter-wave table. A mixer multiplies each input sample by both values, which moves the wanted carrier to 0 Hz as separate in-phase (I) and quadrature (Q) paths at the full input rate.

Each path then passes a third-order cascaded integrator-comb filter that keeps one sample in 32, and an eight-tap symmetric FIR filter that keeps one result in four. The FIR uses one multiplier per path over eight successive clocks. With a 37.05 MHz input rate and a tuning word of round(2^32 x 10.7 / 37.05) = 1240381918, a 10.7 MHz carrier lands at 0 Hz and the outputs come out at 289.45 kHz as 24-bit signed words, rounded and saturated. The filters start from zero after reset and produce nothing until they hold enough history.

Top module: `ddc_decimator`

## Requirements
- R1: While reset is active and after it is released, out_valid is 0 and out_i and out_q are 0 until the first result, and all filter state starts at zero.
- R2: A 32-bit phase accumulator advances by tune_word once for each cycle with in_valid high; the sample accepted in that cycle uses the phase value from before the addition, so a new tune_word takes effect from the next accepted sample.
- R3: The table index n is the top 10 bits of the phase. With quadrant q = n[9:8] and a = n[7:0], the magnitude is round(32767 x sin(2 pi (a' + 0.5) / 1024)) where a' = 255 - a for odd q and a' = a otherwise; sine is negative for q of 2 or 3. Cosine is the sine of (n + 256) mod 1024.
- R4: The mixed values are I = floor(x x cos / 2^15) and Q = floor(-(x x sin) / 2^15), each 13 bits signed, for a 12-bit signed input x.
- R5: The integrator filter has three 28-bit wrapping stages; on each accepted sample stage 1 adds the mixed value and stages 2 and 3 add the value the previous stage held before that update. On every 32nd accepted sample the new third-stage value passes three differencing stages, each subtracting the input it received at the previous decimation.
- R6: The FIR weights are -4, 6, 30, 32, 32, 30, 6, -4 over the eight newest decimated samples, and a result is produced on every fourth decimated sample, i.e. once per 128 accepted inputs.
- R7: No result appears before the eighth decimated sample after reset, i.e. before the 256th accepted input; the first result is formed then.
- R8: The FIR sum is rounded by adding 256 and shifting right arithmetically by 9 (ties go upward).
- R9: A rounded result outside the 24-bit signed range is clamped to 8388607 or -8388608.
- R10: out_i and out_q are valid together under a single out_valid pulse that lasts one cycle.
- R11: Cycles with in_valid low change no state: in_sample is ignored, the phase holds, and the result sequence is the same as with no gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Qualifies in_sample for this cycle |
| in_sample | input | 12 | Real IF sample, two's complement |
| tune_word | input | 32 | Phase increment per accepted sample |
| out_valid | output | 1 | One-cycle strobe for a new I/Q pair |
| out_i | output | 24 | In-phase baseband result, two's complement |
| out_q | output | 24 | Quadrature baseband result, two's complement |

## Verification
The case of interest is a new input sample being accepted, with integrators and oscillator moving, in the same cycle as the FIR finishing its shared-multiplier sum and presenting a result. Long gap-free bursts make every FIR pass and every output strobe coincide with live input, while runs with random gaps move that alignment around. Each result is judged against a sample-by-sample bench model of oscillator, mixer, integrator-comb and FIR, so any disturbance of the history during the sum shows up as a mismatch.

// File: rtl/ddc_pkg.sv
package ddc_pkg;
  localparam int IN_W      = 12;
  localparam int TRIG_W    = 16;
  localparam int LUT_AW    = 8;
  localparam int PHASE_W   = 32;
  localparam int CIC_N     = 3;
  localparam int CIC_RLOG  = 5;
  localparam int FIR_N     = 8;
  localparam int FIR_DEC   = 4;
  localparam int COEF_W    = 8;
  localparam int OUT_W     = 24;
  localparam int OUT_SHIFT = 9;

  localparam int MIX_W = IN_W + 1;
  localparam int CIC_W = MIX_W + CIC_N * CIC_RLOG;
  localparam int ACC_W = CIC_W + COEF_W + $clog2(FIR_N);

  localparam logic signed [COEF_W-1:0] FIR_COEF [FIR_N] =
    '{-8'sd4, 8'sd6, 8'sd30, 8'sd32, 8'sd32, 8'sd30, 8'sd6, -8'sd4};

  // magnitude of one quarter-wave entry, half-step offset keeps the mirror exact
  function automatic int quarter_sine(int a, int qn, int amp_bits);
    real ang;
    real v;
    ang = 2.0 * 3.14159265358979 * (real'(a) + 0.5) / real'(4 * qn);
    v   = real'((1 << (amp_bits - 1)) - 1) * $sin(ang);
    return $rtoi(v + 0.5);
  endfunction
endpackage

// File: rtl/ddc_nco.sv
module ddc_nco
  import ddc_pkg::*;
#(
  parameter int PW = PHASE_W,
  parameter int AW = LUT_AW,
  parameter int TW = TRIG_W
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 step_en,
  input  logic [PW-1:0]        tune_word,
  output logic signed [TW-1:0] cos_o,
  output logic signed [TW-1:0] sin_o
);
  localparam int IW = AW + 2;
  localparam int QN = 1 << AW;

  logic [PW-1:0] phase_q, phase_d;
  logic [TW-2:0] lut [QN];

  for (genvar g = 0; g < QN; g++) begin : g_lut
    localparam int V = quarter_sine(g, QN, TW);
    assign lut[g] = (TW-1)'(V);
  end

  function automatic logic signed [TW-1:0] lookup(input logic [IW-1:0] ix);
    logic [AW-1:0]        addr;
    logic signed [TW-1:0] mag;
    addr = ix[IW-2] ? ~ix[AW-1:0] : ix[AW-1:0];
    mag  = signed'({1'b0, lut[addr]});
    return ix[IW-1] ? -mag : mag;
  endfunction

  always_comb begin
    phase_d = phase_q;
    if (step_en) phase_d = phase_q + tune_word;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) phase_q <= '0;
    else         phase_q <= phase_d;
  end

  always_comb begin
    sin_o = lookup(phase_q[PW-1 -: IW]);
    cos_o = lookup(phase_q[PW-1 -: IW] + IW'(QN));
  end

  // R11: phase must not move on idle cycles
  a_r11_phase_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !step_en |=> $stable(phase_q));
endmodule

// File: rtl/ddc_mixer.sv
module ddc_mixer
  import ddc_pkg::*;
#(
  parameter int XW = IN_W,
  parameter int TW = TRIG_W,
  parameter int MW = MIX_W
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 in_valid,
  input  logic signed [XW-1:0] in_sample,
  input  logic signed [TW-1:0] cos_i,
  input  logic signed [TW-1:0] sin_i,
  output logic                 mix_valid,
  output logic signed [MW-1:0] mix_i,
  output logic signed [MW-1:0] mix_q
);
  localparam int PW = XW + TW;

  logic signed [PW-1:0] prod_i, prod_q;
  logic signed [MW-1:0] mi_d, mq_d;
  logic                 vld_d;

  always_comb begin
    prod_i = in_sample * cos_i;
    prod_q = -(in_sample * sin_i);
    vld_d  = in_valid;
    mi_d   = mix_i;
    mq_d   = mix_q;
    if (in_valid) begin
      mi_d = MW'(prod_i >>> (TW - 1));
      mq_d = MW'(prod_q >>> (TW - 1));
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      mix_valid <= 1'b0;
      mix_i     <= '0;
      mix_q     <= '0;
    end else begin
      mix_valid <= vld_d;
      mix_i     <= mi_d;
      mix_q     <= mq_d;
    end
  end

  // R11: an idle input cycle leaves the mixer outputs untouched
  a_r11_mix_hold: assert property (@(posedge clk) disable iff (!rst_ni)
    !in_valid |=> (!mix_valid && $stable(mix_i) && $stable(mix_q)));
endmodule

// File: rtl/ddc_cic.sv
module ddc_cic
  import ddc_pkg::*;
#(
  parameter int IW = MIX_W,
  parameter int N  = CIC_N,
  parameter int RL = CIC_RLOG,
  parameter int CW = IW + N * RL
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [CW-1:0] out_data
);
  localparam logic [RL-1:0] LAST = RL'((1 << RL) - 1);

  logic signed [CW-1:0] integ_q [N];
  logic signed [CW-1:0] integ_d [N];
  logic signed [CW-1:0] dly_q   [N];
  logic signed [CW-1:0] dly_d   [N];
  logic signed [CW-1:0] cmb     [N+1];
  logic [RL-1:0]        cnt_q, cnt_d;
  logic                 dec;
  logic signed [CW-1:0] out_d;
  logic                 vld_d;

  always_comb begin
    integ_d = integ_q;
    dly_d   = dly_q;
    cnt_d   = cnt_q;
    out_d   = out_data;
    vld_d   = 1'b0;
    dec     = in_valid && (cnt_q == LAST);
    if (in_valid) begin
      integ_d[0] = integ_q[0] + CW'(in_data);
      for (int k = 1; k < N; k++) integ_d[k] = integ_q[k] + integ_q[k-1];
      cnt_d = cnt_q + 1'b1;
    end
    cmb[0] = integ_d[N-1];
    for (int k = 0; k < N; k++) cmb[k+1] = cmb[k] - dly_q[k];
    if (dec) begin
      for (int k = 0; k < N; k++) dly_d[k] = cmb[k];
      out_d = cmb[N];
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      integ_q   <= '{default: '0};
      dly_q     <= '{default: '0};
      cnt_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      integ_q   <= integ_d;
      dly_q     <= dly_d;
      cnt_q     <= cnt_d;
      out_data  <= out_d;
      out_valid <= vld_d;
    end
  end

  // R5: a decimated sample is only produced by an accepted input
  a_r5_dec_on_sample: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> $past(in_valid));
  // R5: decimation strobes never come back to back
  a_r5_dec_single: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |=> !out_valid);
endmodule

// File: rtl/ddc_fir.sv
module ddc_fir
  import ddc_pkg::*;
#(
  parameter int IW    = CIC_W,
  parameter int TAPS  = FIR_N,
  parameter int DEC   = FIR_DEC,
  parameter int CFW   = COEF_W,
  parameter int OW    = OUT_W,
  parameter int SHIFT = OUT_SHIFT,
  parameter int AW    = IW + CFW + $clog2(TAPS)
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic                 in_valid,
  input  logic signed [IW-1:0] in_data,
  output logic                 out_valid,
  output logic signed [OW-1:0] out_data
);
  localparam int KW = $clog2(TAPS);
  localparam int FW = $clog2(TAPS + 1);
  localparam int PHW = (DEC > 1) ? $clog2(DEC) : 1;
  localparam logic signed [AW-1:0] HALF = AW'(1) <<< (SHIFT - 1);

  logic signed [IW-1:0]     taps_q [TAPS];
  logic signed [IW-1:0]     taps_d [TAPS];
  logic [PHW-1:0]           ph_q, ph_d;
  logic [FW-1:0]            fill_q, fill_d;
  logic [KW-1:0]            k_q, k_d;
  logic                     busy_q, busy_d, fin_q, fin_d;
  logic signed [AW-1:0]     acc_q, acc_d;
  logic signed [IW+CFW-1:0] prod;
  logic signed [AW-1:0]     rnd, sh;
  logic                     ovf;
  logic signed [OW-1:0]     sat, out_d;
  logic                     vld_d;

  always_comb begin
    prod = taps_q[k_q] * FIR_COEF[k_q];
    rnd  = acc_q + HALF;
    sh   = rnd >>> SHIFT;
    ovf  = sh[AW-1:OW-1] != {(AW-OW+1){sh[AW-1]}};
    sat  = ovf ? {sh[AW-1], {(OW-1){~sh[AW-1]}}} : sh[OW-1:0];
  end

  always_comb begin
    taps_d = taps_q;
    ph_d   = ph_q;
    fill_d = fill_q;
    k_d    = k_q;
    busy_d = busy_q;
    fin_d  = 1'b0;
    acc_d  = acc_q;
    out_d  = out_data;
    vld_d  = 1'b0;
    if (in_valid) begin
      taps_d[0] = in_data;
      for (int t = 1; t < TAPS; t++) taps_d[t] = taps_q[t-1];
      ph_d = (ph_q == PHW'(DEC - 1)) ? '0 : ph_q + 1'b1;
      if (fill_q != FW'(TAPS)) fill_d = fill_q + 1'b1;
      if (ph_q == PHW'(DEC - 1) && fill_q >= FW'(TAPS - 1)) begin
        busy_d = 1'b1;
        k_d    = '0;
        acc_d  = '0;
      end
    end
    if (busy_q) begin
      acc_d = acc_q + AW'(prod);
      k_d   = k_q + 1'b1;
      if (k_q == KW'(TAPS - 1)) begin
        busy_d = 1'b0;
        fin_d  = 1'b1;
      end
    end
    if (fin_q) begin
      out_d = sat;
      vld_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      taps_q    <= '{default: '0};
      ph_q      <= '0;
      fill_q    <= '0;
      k_q       <= '0;
      busy_q    <= 1'b0;
      fin_q     <= 1'b0;
      acc_q     <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      taps_q    <= taps_d;
      ph_q      <= ph_d;
      fill_q    <= fill_d;
      k_q       <= k_d;
      busy_q    <= busy_d;
      fin_q     <= fin_d;
      acc_q     <= acc_d;
      out_data  <= out_d;
      out_valid <= vld_d;
    end
  end

  // R6: the shared multiplier is never mid-sum when new history arrives
  a_r6_mac_quiet: assert property (@(posedge clk) disable iff (!rst_ni)
    in_valid |-> !busy_q);
  // R7: a result implies the full history has been gathered
  a_r7_filled: assert property (@(posedge clk) disable iff (!rst_ni)
    out_valid |-> (fill_q == FW'(TAPS)));
endmodule

// File: rtl/ddc_decimator.sv
module ddc_decimator
  import ddc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_sample,
  input  logic [PHASE_W-1:0]      tune_word,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_i,
  output logic signed [OUT_W-1:0] out_q
);
  logic [1:0] rst_sync;
  logic       rst_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_i = rst_sync[1];

  logic signed [TRIG_W-1:0] cos_w, sin_w;
  logic                     mix_vld;
  logic signed [MIX_W-1:0]  mix_i, mix_q;
  logic [1:0]               cic_vld, fir_vld;
  logic [1:0][CIC_W-1:0]    cic_data;
  logic [1:0][OUT_W-1:0]    fir_data;

  ddc_nco u_nco (
    .clk       (clk),
    .rst_ni    (rst_i),
    .step_en   (in_valid),
    .tune_word (tune_word),
    .cos_o     (cos_w),
    .sin_o     (sin_w)
  );

  ddc_mixer u_mix (
    .clk       (clk),
    .rst_ni    (rst_i),
    .in_valid  (in_valid),
    .in_sample (in_sample),
    .cos_i     (cos_w),
    .sin_i     (sin_w),
    .mix_valid (mix_vld),
    .mix_i     (mix_i),
    .mix_q     (mix_q)
  );

  for (genvar p = 0; p < 2; p++) begin : g_path
    logic signed [MIX_W-1:0] path_in;
    assign path_in = (p == 0) ? mix_i : mix_q;

    ddc_cic u_cic (
      .clk       (clk),
      .rst_ni    (rst_i),
      .in_valid  (mix_vld),
      .in_data   (path_in),
      .out_valid (cic_vld[p]),
      .out_data  (cic_data[p])
    );

    ddc_fir u_fir (
      .clk       (clk),
      .rst_ni    (rst_i),
      .in_valid  (cic_vld[p]),
      .in_data   (cic_data[p]),
      .out_valid (fir_vld[p]),
      .out_data  (fir_data[p])
    );
  end

  assign out_valid = fir_vld[0];
  assign out_i     = fir_data[0];
  assign out_q     = fir_data[1];

  // R10: both paths deliver in the same cycle
  a_r10_iq_together: assert property (@(posedge clk) disable iff (!rst_i)
    fir_vld[0] == fir_vld[1]);
  // R10: the output strobe lasts exactly one cycle
  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_i)
    out_valid |=> !out_valid);
endmodule

// File: tb/sim_ddc_decimator.sv
module sim_ddc_decimator;
  logic               clk = 1'b0;
  logic               rst_n;
  logic               in_valid;
  logic signed [11:0] in_sample;
  logic [31:0]        tune_word;
  logic               out_valid;
  logic signed [23:0] out_i, out_q;

  always #2 clk = ~clk;

  ddc_decimator u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .tune_word(tune_word), .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  int n_chk = 0, n_bad = 0, seen = 0;
  bit prev_vld = 0, done = 0;
  longint last_i = 0;

  // reference model state
  longint m_phase;
  longint m_int [2][3];
  longint m_dly [2][3];
  longint m_tap [2][8];
  int     m_dcnt, m_fph, m_fill;
  int     coef [8] = '{-4, 6, 30, 32, 32, 30, 6, -4};
  longint exp_i [$];
  longint exp_q [$];
  string  exp_t [$];
  string  tag;

  function automatic longint wrapw(longint v, int w);
    longint t;
    t = v <<< (64 - w);
    return t >>> (64 - w);
  endfunction

  function automatic longint q_sine(int a);
    real v;
    v = 32767.0 * $sin(2.0 * 3.14159265358979 * (real'(a) + 0.5) / 1024.0);
    return longint'($rtoi(v + 0.5));
  endfunction

  function automatic longint trig(longint n);
    int q, a;
    longint v;
    q = int'(n >> 8) & 3;
    a = int'(n) & 255;
    if (q % 2 == 1) a = 255 - a;
    v = q_sine(a);
    return (q >= 2) ? -v : v;
  endfunction

  function automatic longint fir_eval(int p);
    longint acc, r;
    acc = 0;
    for (int k = 0; k < 8; k++) acc += longint'(coef[k]) * m_tap[p][k];
    r = (acc + 256) >>> 9;
    if (r > 8388607) r = 8388607;
    if (r < -8388608) r = -8388608;
    return r;
  endfunction

  function automatic void model_reset();
    m_phase = 0; m_dcnt = 0; m_fph = 0; m_fill = 0;
    for (int p = 0; p < 2; p++) begin
      for (int k = 0; k < 3; k++) begin m_int[p][k] = 0; m_dly[p][k] = 0; end
      for (int k = 0; k < 8; k++) m_tap[p][k] = 0;
    end
  endfunction

  function automatic void model_step(int x, longint tw);
    longint idx, mv [2], n0, n1, n2, cv, cs, newc [2];
    idx   = (m_phase >> 22) & 1023;
    mv[0] = (longint'(x) * trig((idx + 256) & 1023)) >>> 15;
    mv[1] = (-(longint'(x) * trig(idx))) >>> 15;
    m_phase = (m_phase + tw) & 64'hFFFF_FFFF;
    for (int p = 0; p < 2; p++) begin
      n0 = wrapw(m_int[p][0] + mv[p], 28);
      n1 = wrapw(m_int[p][1] + m_int[p][0], 28);
      n2 = wrapw(m_int[p][2] + m_int[p][1], 28);
      m_int[p][0] = n0; m_int[p][1] = n1; m_int[p][2] = n2;
      cv = n2;
      if (m_dcnt == 31) begin
        for (int k = 0; k < 3; k++) begin
          cs = wrapw(cv - m_dly[p][k], 28);
          m_dly[p][k] = cv;
          cv = cs;
        end
      end
      newc[p] = cv;
    end
    if (m_dcnt == 31) begin
      m_dcnt = 0;
      for (int p = 0; p < 2; p++) begin
        for (int k = 7; k > 0; k--) m_tap[p][k] = m_tap[p][k-1];
        m_tap[p][0] = newc[p];
      end
      if (m_fph == 3 && m_fill >= 7) begin
        exp_i.push_back(fir_eval(0));
        exp_q.push_back(fir_eval(1));
        exp_t.push_back(tag);
      end
      if (m_fill < 8) m_fill++;
      m_fph = (m_fph + 1) % 4;
    end else begin
      m_dcnt++;
    end
  endfunction

  function automatic void check(string t, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", t, what, act, exp);
    end
  endfunction

  always @(negedge clk) begin
    if (out_valid) begin
      seen++;
      check("R10", "strobe width", longint'(prev_vld), 0);
      if (exp_i.size() == 0) begin
        check("R7", "unexpected out_valid", 1, 0);
      end else begin
        string t;
        t = exp_t.pop_front();
        check(t, "out_i", longint'(out_i), exp_i.pop_front());
        check(t, "out_q", longint'(out_q), exp_q.pop_front());
        last_i = longint'(out_i);
      end
    end
    prev_vld = out_valid;
  end

  task automatic idle();
    in_valid  = 1'b0;
    in_sample = 12'($urandom);
    @(negedge clk);
  endtask

  task automatic push(int x);
    in_valid  = 1'b1;
    in_sample = 12'(x);
    model_step(x, longint'(tune_word));
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic run(int n, bit gaps, int mode);
    for (int s = 0; s < n; s++) begin
      if (gaps && ($urandom % 4 == 0)) begin
        for (int g = 0; g < 1 + int'($urandom % 3); g++) idle();
      end
      case (mode)
        1:       push(2047);
        2:       push(-2048);
        default: push(int'($urandom_range(4095)) - 2048);
      endcase
    end
  endtask

  task automatic drain(string t);
    for (int c = 0; c < 60; c++) idle();
    check(t, "pending results", longint'(exp_i.size()), 0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    model_reset();
    repeat (3) @(negedge clk);
    check("R1", "out_valid in reset", longint'(out_valid), 0);
    check("R1", "out_i in reset", longint'(out_i), 0);
    check("R1", "out_q in reset", longint'(out_q), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R6 watchdog: actual=timeout expected=completion");
      summary();
      $finish;
    end
  end

  initial begin
    int base;
    void'($urandom(32'd20250611));
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; tune_word = 32'd1240381918;
    do_reset();
    check("R1", "out_valid after release", longint'(out_valid), 0);

    // random IF samples with gaps and garbage on idle cycles
    tag = "R2/R3/R4/R5/R6/R8/R11";
    run(2048, 1'b1, 0);
    tag = "R2 retune";
    tune_word = $urandom;
    run(1024, 1'b1, 0);
    drain("R6");

    // restart from reset: nothing before the 256th sample, one result by 300
    do_reset();
    check("R1", "out_i after reset", longint'(out_i), 0);
    base = seen;
    tag = "R7";
    run(255, 1'b1, 0);
    for (int c = 0; c < 40; c++) idle();
    check("R7", "results before fill", longint'(seen - base), 0);
    run(45, 1'b1, 0);
    drain("R7");
    check("R7", "results after 300 samples", longint'(seen - base), 1);

    // full-scale DC at zero tuning drives both clamps
    do_reset();
    tune_word = 32'd0;
    tag = "R9 high";
    run(1024, 1'b0, 1);
    drain("R9");
    check("R9", "positive clamp", last_i, 8388607);
    tag = "R9 low";
    run(1024, 1'b0, 2);
    drain("R9");
    check("R9", "negative clamp", last_i, -8388608);

    // gap-free burst: every FIR pass overlaps live input
    tag = "R10 burst";
    tune_word = 32'd1240381918;
    run(1536, 1'b0, 0);
    drain("R10");

    done = 1;
    summary();
    $finish;
  end
endmodule